// File: doc/BRIEF.md
# ATA Strobe Timing Generator

This block produces the read and write strobes of a parallel ATA channel for programmed-I/O and multiword DMA transfers. Every duration comes from one packed 32-bit timing word. Each request names one of two cycle kinds. A register cycle accesses the task-file registers. A data cycle moves a transfer word. For each request the block holds the strobe high for an optional setup phase, drives it low for an active phase, and then holds it high for a recovery phase. All three phases are counted in bus clocks.

A burst opens when a request arrives while the block is idle. The timing word is captured at that moment and held until the burst ends. The setup phase runs only on the first cycle of a burst. A request presented in the final recovery clock is taken at once, and its active phase follows in the very next clock, so back-to-back cycles carry no idle gap. When the word's Ultra DMA enable is set, data cycles belong to a different engine. Such data requests are dropped here, while register cycles still run.

Top module: `ata_strobe_gen`

## Requirements
- R1: After reset, and whenever no cycle is running, dior_n and diow_n are high, done is low and req_ready is high.
- R2: In a data cycle (req_data=1) the strobe stays low for timing_word[8:4]+1 clocks. dior_n is the strobe when req_write=0 and diow_n when req_write=1.
- R3: In a data cycle the strobe is high for timing_word[3:0]+1 recovery clocks after the active phase. done is high for exactly the last of those clocks.
- R4: In a register cycle (req_data=0) the active phase lasts timing_word[17:13]+1 clocks and recovery lasts timing_word[12:9]+1 clocks, with done in the last recovery clock.
- R5: A data cycle that opens a burst is preceded by timing_word[24:22] clocks with the strobe high. A value of zero adds no clocks.
- R6: A register cycle that opens a burst is preceded by timing_word[27:25] clocks with the strobe high.
- R7: A request held valid in a done clock is accepted at that edge. Its strobe goes low in the next clock, with no setup phase.
- R8: The timing word is sampled when a burst opens. Changes to timing_word while the burst runs do not affect any of its cycles.
- R9: When bit 28 of the sampled word is set, a data request produces no strobe and no done, and the block returns to or stays idle. Register cycles are unaffected.
- R10: The two strobes are never low at the same time. The strobe for the other direction stays high during a cycle.
- R11: A request is accepted on a clock edge where req_valid and req_ready are both high. req_ready is high when idle and in the done clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| timing_word | input | 32 | Packed timing word, sampled at burst start |
| req_valid | input | 1 | Request present |
| req_data | input | 1 | 1 = data cycle, 0 = register cycle |
| req_write | input | 1 | 1 = write (diow_n), 0 = read (dior_n) |
| req_ready | output | 1 | Request can be taken this clock |
| dior_n | output | 1 | Read strobe, active low |
| diow_n | output | 1 | Write strobe, active low |
| done | output | 1 | One-clock pulse in the final recovery clock |

## Verification
The assertions assume that req_data and req_write are steady in the clock where a request is accepted. They also assume that the timing word needs to be meaningful only on the edge that opens a burst. The bench drives every request input at the falling edge and holds it until a rising edge has taken it. It changes timing_word freely while bursts run, which exercises the capture rule. The sweeps walk every value of each active and recovery field and every setup value for both cycle kinds, in both directions. Directed chains cover back-to-back cycles and blocked data requests.

// File: rtl/ata_strobe_pkg.sv
package ata_strobe_pkg;

  localparam int TW_W    = 32;
  localparam int HI_W    = 4;
  localparam int LO_W    = 5;
  localparam int PRE_W   = 3;
  localparam int CNT_W   = (LO_W > HI_W) ? LO_W : HI_W;

  // field positions of the packed timing word
  localparam int D_HI_LSB = 0;
  localparam int D_LO_LSB = 4;
  localparam int C_HI_LSB = 9;
  localparam int C_LO_LSB = 13;
  localparam int D_PRE_LSB = 22;
  localparam int C_PRE_LSB = 25;
  localparam int UDMA_BIT  = 28;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_PRE  = 2'd1,
    PH_ACT  = 2'd2,
    PH_RCV  = 2'd3
  } phase_e;

  typedef struct packed {
    logic [HI_W-1:0]  d_hi;
    logic [LO_W-1:0]  d_lo;
    logic [HI_W-1:0]  c_hi;
    logic [LO_W-1:0]  c_lo;
    logic [PRE_W-1:0] d_pre;
    logic [PRE_W-1:0] c_pre;
    logic             udma_en;
  } tw_fields_t;

  function automatic tw_fields_t tw_decode(input logic [TW_W-1:0] w);
    tw_fields_t f;
    f.d_hi    = w[D_HI_LSB  +: HI_W];
    f.d_lo    = w[D_LO_LSB  +: LO_W];
    f.c_hi    = w[C_HI_LSB  +: HI_W];
    f.c_lo    = w[C_LO_LSB  +: LO_W];
    f.d_pre   = w[D_PRE_LSB +: PRE_W];
    f.c_pre   = w[C_PRE_LSB +: PRE_W];
    f.udma_en = w[UDMA_BIT];
    return f;
  endfunction

  // counter load for the low phase: lasts load+1 clocks
  function automatic logic [CNT_W-1:0] active_load(input tw_fields_t f, input logic is_data);
    return is_data ? CNT_W'(f.d_lo) : CNT_W'(f.c_lo);
  endfunction

  // counter load for the recovery phase: lasts load+1 clocks
  function automatic logic [CNT_W-1:0] recovery_load(input tw_fields_t f, input logic is_data);
    return is_data ? CNT_W'(f.d_hi) : CNT_W'(f.c_hi);
  endfunction

  // setup clocks applied to the first cycle of a burst
  function automatic logic [PRE_W-1:0] setup_len(input tw_fields_t f, input logic is_data);
    return is_data ? f.d_pre : f.c_pre;
  endfunction

endpackage

// File: rtl/ata_phase_timer.sv
module ata_phase_timer #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/ata_tw_capture.sv
module ata_tw_capture
  import ata_strobe_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            capture,
  input  logic [TW_W-1:0] word_in,
  output tw_fields_t      cur
);

  logic [TW_W-1:0] word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       word_q <= '0;
    else if (capture) word_q <= word_in;
  end

  // the opening cycle sees the incoming word, later ones the held copy
  assign cur = capture ? tw_decode(word_in) : tw_decode(word_q);

endmodule

// File: rtl/ata_strobe_seq.sv
module ata_strobe_seq
  import ata_strobe_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_data,
  input  logic             req_write,
  input  tw_fields_t       cur,
  input  logic             expired,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             capture,
  output logic             launch,
  output logic             req_ready,
  output logic             done,
  output logic             dior_n,
  output logic             diow_n
);

  phase_e     ph, ph_n;
  logic       kind_q, wr_q;
  logic       accept, blocked;
  logic [PRE_W-1:0] pre_v;

  assign done      = (ph == PH_RCV) && expired;
  assign req_ready = (ph == PH_IDLE) || done;
  assign accept    = req_valid && req_ready;
  assign capture   = accept && (ph == PH_IDLE);
  assign blocked   = req_data && cur.udma_en;
  assign launch    = accept && !blocked;
  assign pre_v     = setup_len(cur, req_data);

  always_comb begin
    ph_n     = ph;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (ph)
      PH_IDLE: if (launch) begin
        tmr_load = 1'b1;
        if (pre_v != '0) begin
          ph_n    = PH_PRE;
          tmr_val = CNT_W'(pre_v) - 1'b1;
        end else begin
          ph_n    = PH_ACT;
          tmr_val = active_load(cur, req_data);
        end
      end
      PH_PRE: if (expired) begin
        ph_n     = PH_ACT;
        tmr_load = 1'b1;
        tmr_val  = active_load(cur, kind_q);
      end
      PH_ACT: if (expired) begin
        ph_n     = PH_RCV;
        tmr_load = 1'b1;
        tmr_val  = recovery_load(cur, kind_q);
      end
      PH_RCV: if (expired) begin
        if (launch) begin
          ph_n     = PH_ACT;
          tmr_load = 1'b1;
          tmr_val  = active_load(cur, req_data);
        end else begin
          ph_n = PH_IDLE;
        end
      end
      default: ph_n = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph     <= PH_IDLE;
      kind_q <= 1'b0;
      wr_q   <= 1'b0;
    end else begin
      ph <= ph_n;
      if (launch) begin
        kind_q <= req_data;
        wr_q   <= req_write;
      end
    end
  end

  assign dior_n = !((ph == PH_ACT) && !wr_q);
  assign diow_n = !((ph == PH_ACT) &&  wr_q);

  // R10: never both strobes active
  p_one_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(!dior_n && !diow_n));

  // R3: done falls in a recovery clock with strobes released
  p_done_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (dior_n && diow_n));

  // R3: done is a single-clock pulse
  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7: a request taken in the done clock strobes at once
  p_b2b_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && launch) |=> (!dior_n || !diow_n));

  // R9: blocked data request leaves the bus quiet
  p_udma_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && blocked) |=> (dior_n && diow_n && !done && req_ready));

  // R11: a taken request leaves idle or keeps the chain running
  p_ready_leave_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && !blocked) |=> !req_ready);

endmodule

// File: rtl/ata_strobe_gen.sv
module ata_strobe_gen
  import ata_strobe_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [TW_W-1:0] timing_word,
  input  logic            req_valid,
  input  logic            req_data,
  input  logic            req_write,
  output logic            req_ready,
  output logic            dior_n,
  output logic            diow_n,
  output logic            done
);

  tw_fields_t       cur;
  logic             capture, launch, expired, tmr_load;
  logic [CNT_W-1:0] tmr_val;

  ata_tw_capture u_capture (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (capture),
    .word_in (timing_word),
    .cur     (cur)
  );

  ata_phase_timer #(.CW(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (expired)
  );

  ata_strobe_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_data  (req_data),
    .req_write (req_write),
    .cur       (cur),
    .expired   (expired),
    .tmr_load  (tmr_load),
    .tmr_val   (tmr_val),
    .capture   (capture),
    .launch    (launch),
    .req_ready (req_ready),
    .done      (done),
    .dior_n    (dior_n),
    .diow_n    (diow_n)
  );

endmodule

// File: tb/test_ata_strobe_gen.sv
module test_ata_strobe_gen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] tw = '0;
  logic        req_valid = 1'b0, req_data = 1'b0, req_write = 1'b0;
  logic        req_ready, dior_n, diow_n, done;
  int          n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  ata_strobe_gen i_ata_strobe_gen (
    .clk(clk), .rst_n(rst_n), .timing_word(tw), .req_valid(req_valid),
    .req_data(req_data), .req_write(req_write), .req_ready(req_ready),
    .dior_n(dior_n), .diow_n(diow_n), .done(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int e_pre(input logic [31:0] w, input bit d);
    return d ? int'((w >> 22) & 7) : int'((w >> 25) & 7);
  endfunction
  function automatic int e_lo(input logic [31:0] w, input bit d);
    return d ? int'((w >> 4) & 31) + 1 : int'((w >> 13) & 31) + 1;
  endfunction
  function automatic int e_hi(input logic [31:0] w, input bit d);
    return d ? int'(w & 15) + 1 : int'((w >> 9) & 15) + 1;
  endfunction
  function automatic logic [31:0] mk(input int dhi, dlo, chi, clo, dpre, cpre, udma);
    return (32'(dhi) & 32'hF) | ((32'(dlo) & 32'h1F) << 4) | ((32'(chi) & 32'hF) << 9) |
           ((32'(clo) & 32'h1F) << 13) | ((32'(dpre) & 7) << 22) |
           ((32'(cpre) & 7) << 25) | ((32'(udma) & 1) << 28) | 32'h2000_0000;
  endfunction

  // Follows one cycle from the clock after its accepting edge.
  task automatic measure(input string tag, input logic [31:0] w, input bit d, input bit wr,
                         input int xpre, input bit nv, input bit nd, input bit nwr,
                         input logic [31:0] nw);
    int pre = 0, lo = 0, hi = 0, wrong = 0, stage = 0, guard = 0;
    bit first = 1;
    bit mine, other;
    while (stage < 3 && guard < 200) begin
      @(negedge clk);
      guard++;
      if (first) begin
        req_valid = nv; req_data = nd; req_write = nwr; tw = nw; first = 0;
      end
      mine  = wr ? !diow_n : !dior_n;
      other = wr ? !dior_n : !diow_n;
      if (other) wrong++;
      case (stage)
        0: if (mine) begin stage = 1; lo = 1; end else pre++;
        1: if (mine) lo++;
           else begin stage = 2; hi = 1; if (done) stage = 3; end
        default: begin hi++; if (done) stage = 3; end
      endcase
    end
    check(pre == xpre, $sformatf("%s setup (%s)", tag, d ? "R5" : "R6"), pre, xpre);
    check(lo == e_lo(w, d), $sformatf("%s active (%s)", tag, d ? "R2" : "R4"), lo, e_lo(w, d));
    check(hi == e_hi(w, d), $sformatf("%s recovery+done (%s)", tag, d ? "R3" : "R4"), hi, e_hi(w, d));
    check(wrong == 0, $sformatf("%s other strobe R10", tag), wrong, 0);
  endtask

  task automatic issue(input logic [31:0] w, input bit d, input bit wr);
    @(negedge clk);
    tw = w; req_data = d; req_write = wr; req_valid = 1'b1;
    check(req_ready == 1'b1, "R11 ready when idle", int'(req_ready), 1);
  endtask

  task automatic quiet(input string tag, input int n);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i == 0) req_valid = 1'b0;
      if (!dior_n || !diow_n || done || !req_ready) bad++;
    end
    check(bad == 0, tag, bad, 0);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(150000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    logic [31:0] w, w2;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(dior_n && diow_n && !done && req_ready, "R1 reset state",
          int'({dior_n, diow_n, done, req_ready}), 4'b1101);
    rst_n = 1'b1;
    @(negedge clk);
    check(dior_n && diow_n && !done && req_ready, "R1 idle after reset",
          int'({dior_n, diow_n, done, req_ready}), 4'b1101);

    // data field sweep: every active value, every recovery and setup value
    for (int v = 0; v < 32; v++) begin
      w = mk(v % 16, v, (v + 5) % 16, 31 - v, v % 8, (v + 3) % 8, 0);
      issue(w, 1'b1, v[0]);
      measure("data", w, 1'b1, v[0], e_pre(w, 1'b1), 1'b0, 1'b0, 1'b0, w);
    end
    // register field sweep
    for (int v = 0; v < 32; v++) begin
      w = mk((v + 7) % 16, 31 - v, (31 - v) % 16, v, (v + 1) % 8, v % 8, 0);
      issue(w, 1'b0, ~v[0]);
      measure("reg", w, 1'b0, ~v[0], e_pre(w, 1'b0), 1'b0, 1'b0, 1'b0, w);
    end

    // R7 and R8: chain a register write behind a data read, change the word mid-burst
    w  = mk(3, 6, 2, 4, 5, 6, 0);
    w2 = mk(9, 17, 11, 20, 1, 1, 0);
    issue(w, 1'b1, 1'b0);
    measure("chain1", w, 1'b1, 1'b0, e_pre(w, 1'b1), 1'b1, 1'b0, 1'b1, w2);
    measure("chain2 R7 R8", w, 1'b0, 1'b1, 0, 1'b0, 1'b0, 1'b0, w2);
    // new burst picks up the new word (R8)
    issue(w2, 1'b0, 1'b0);
    measure("newburst R8", w2, 1'b0, 1'b0, e_pre(w2, 1'b0), 1'b0, 1'b0, 1'b0, w2);

    // three-deep chain, data then data then register (R7)
    w = mk(0, 0, 0, 0, 7, 7, 0);
    issue(w, 1'b1, 1'b1);
    measure("b2b-a R7", w, 1'b1, 1'b1, 7, 1'b1, 1'b1, 1'b0, 32'hFFFF_FFFF);
    measure("b2b-b R7", w, 1'b1, 1'b0, 0, 1'b1, 1'b0, 1'b1, 32'h0);
    measure("b2b-c R7", w, 1'b0, 1'b1, 0, 1'b0, 1'b0, 1'b0, 32'h0);

    // R9: data request with the Ultra DMA bit set is dropped
    w = mk(4, 4, 2, 2, 2, 2, 1);
    issue(w, 1'b1, 1'b0);
    quiet("R9 blocked data from idle", 30);
    // R9: register cycles still run with that bit set, chained data is dropped
    issue(w, 1'b0, 1'b0);
    measure("R9 reg with udma", w, 1'b0, 1'b0, e_pre(w, 1'b0), 1'b1, 1'b1, 1'b1, w);
    quiet("R9 blocked chained data", 30);

    finish_run();
  end

endmodule